// File: doc/BRIEF.md
# Byte-Wide Synthesizer Control Word Loader

This block builds the control word of a phase-accumulator frequency synthesizer from bytes delivered over an 8-bit parallel bus. Each byte is accepted on a byte-load strobe and placed in a staging register. A second strobe, the commit strobe, copies the whole staged word into the active registers in one step. Those registers drive the synthesizer core with a 32-bit tuning word and a 5-bit phase offset. Because of this double buffering, the core never sees a half-written word.

Both strobes come from a host that does not run on the reference clock. Each strobe passes through a two-stage synchroniser and an edge detector before it acts. The bus has no valid/ready handshake: the strobes are plain control pins, and the host gives back-pressure by pacing its strobes. The host must hold `bus_data` stable from the rising edge of the byte-load strobe until three reference-clock cycles later. It must also hold each strobe high, and then low, for at least two reference-clock cycles.

A word is five bytes, sent in a fixed order. The first byte carries the phase offset in its upper five bits. Its lower three bits hold a power-down flag and two control bits, and this block discards them. The next four bytes carry the tuning word, most significant byte first. A status pin, `ready`, shows whether staged bytes are waiting for a commit.

Top module: `dds_word_loader`

## Requirements
- R1: While `rst` is high (a pulse of 5 or more cycles), the block clears the active tuning word, the phase offset, the staging register, the byte pointer and both synchronisers, and `ready` reads 1.
- R2: Each rising edge of `ld_strobe` stores exactly one byte. Holding `ld_strobe` high for many cycles stores no further bytes.
- R3: The byte in position 0 supplies the phase offset from its bits [7:3], and its bits [2:0] have no effect on any output. Bytes in positions 1 to 4 supply tuning word bits [31:24], [23:16], [15:8] and [7:0], in that order.
- R4: `tune_word` and `phase_off` change only when a commit strobe is applied. Byte loads alone leave them unchanged.
- R5: `tune_word` and `phase_off` take the staged values at the third rising clock edge after `upd_strobe` goes high, and hold their old values at the first two edges. This is well within the 10-cycle limit.
- R6: The byte pointer advances on every byte load and wraps to position 0 after position 4, so a sixth byte overwrites position 0.
- R7: A commit returns the byte pointer to position 0, so the next byte lands in position 0.
- R8: `ready` falls to 0 on the first byte load after a commit or a reset, and rises to 1 when a commit is applied.
- R9: If both strobe edges are detected in the same cycle, the commit takes effect and the concurrent byte is discarded.
- R10: Staging positions that are not reloaded keep their earlier contents. A commit after a partial word applies the new bytes together with the older bytes in the other positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_strobe | input | 1 | Byte-load strobe, asynchronous to `clk`, acts on its rising edge |
| upd_strobe | input | 1 | Commit strobe, asynchronous to `clk`, acts on its rising edge |
| bus_data | input | 8 | Parallel data byte |
| tune_word | output | 32 | Active frequency tuning word |
| phase_off | output | 5 | Active phase offset |
| ready | output | 1 | 1 when no staged bytes are waiting for a commit |

## Verification
The first byte is swept through all 256 values, each with a tuning word derived from it. This separates the phase bits from the discarded low bits and catches any swap between the phase field and the tuning field. A single set bit is then walked across all 32 tuning positions, which exposes byte-order and bit-order faults.

Several pointer patterns are tried: a sixth byte, a two-byte partial word, a strobe held high for many cycles, and a byte load that coincides with a commit. Together they tell apart wrap, reset-on-commit, edge detection and commit priority. A commit is also timed edge by edge, which pins down the synchroniser depth. A reset in the middle of a run is followed by an empty commit, which confirms that reset clears the staging register.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;
  localparam int unsigned BUS_W_DEF = 8;
  localparam int unsigned FTW_W_DEF = 32;
  localparam int unsigned PH_W_DEF  = 5;
  localparam int unsigned SYNC_DEF  = 2;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  // one-cycle pulse on a synchronised low-to-high transition
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/byte_stager.sv
module byte_stager #(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned FTW_W  = 32,
  parameter int unsigned PH_W   = 5,
  localparam int unsigned NBYTES = 1 + FTW_W / BUS_W,
  localparam int unsigned PTR_W  = $clog2(NBYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             clr,
  input  logic [BUS_W-1:0] din,
  output logic [PH_W-1:0]  ph_stage,
  output logic [FTW_W-1:0] ftw_stage,
  output logic [PTR_W-1:0] ptr
);
  logic wr;
  assign wr = ld & ~clr;  // commit wins over a coinciding byte

  always_ff @(posedge clk) begin
    if (rst || clr)                           ptr <= '0;
    else if (ld && ptr == PTR_W'(NBYTES - 1)) ptr <= '0;
    else if (ld)                              ptr <= ptr + 1'b1;
  end

  // position 0: only the phase field is kept, the low bits are dropped
  always_ff @(posedge clk) begin
    if (rst)                     ph_stage <= '0;
    else if (wr && ptr == '0)    ph_stage <= din[BUS_W-1 -: PH_W];
  end

  // positions 1..NBYTES-1: tuning bytes, most significant first
  for (genvar k = 1; k < NBYTES; k++) begin : g_tbyte
    always_ff @(posedge clk) begin
      if (rst)                              ftw_stage[FTW_W-k*BUS_W +: BUS_W] <= '0;
      else if (wr && ptr == PTR_W'(k))      ftw_stage[FTW_W-k*BUS_W +: BUS_W] <= din;
    end
  end
endmodule

// File: rtl/word_commit.sv
module word_commit #(
  parameter int unsigned FTW_W = 32,
  parameter int unsigned PH_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             upd,
  input  logic [PH_W-1:0]  ph_stage,
  input  logic [FTW_W-1:0] ftw_stage,
  output logic [FTW_W-1:0] tune_word,
  output logic [PH_W-1:0]  phase_off,
  output logic             ready
);
  logic busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      tune_word <= '0;
      phase_off <= '0;
    end else if (upd) begin
      tune_word <= ftw_stage;
      phase_off <= ph_stage;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || upd) busy <= 1'b0;
    else if (ld)    busy <= 1'b1;
  end

  assign ready = ~busy;
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
  import dds_ldr_pkg::*;
#(
  parameter int unsigned BUS_W       = BUS_W_DEF,
  parameter int unsigned FTW_W       = FTW_W_DEF,
  parameter int unsigned PH_W        = PH_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF,
  localparam int unsigned NBYTES     = 1 + FTW_W / BUS_W,
  localparam int unsigned PTR_W      = $clog2(NBYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_strobe,
  input  logic             upd_strobe,
  input  logic [BUS_W-1:0] bus_data,
  output logic [FTW_W-1:0] tune_word,
  output logic [PH_W-1:0]  phase_off,
  output logic             ready
);
  logic             ld_pulse, upd_pulse;
  logic [PH_W-1:0]  ph_stage;
  logic [FTW_W-1:0] ftw_stage;
  logic [PTR_W-1:0] ptr;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_ld_sync (
    .clk(clk), .rst(rst), .async_in(ld_strobe), .rise(ld_pulse));

  strobe_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
    .clk(clk), .rst(rst), .async_in(upd_strobe), .rise(upd_pulse));

  byte_stager #(.BUS_W(BUS_W), .FTW_W(FTW_W), .PH_W(PH_W)) u_stage (
    .clk(clk), .rst(rst), .ld(ld_pulse), .clr(upd_pulse), .din(bus_data),
    .ph_stage(ph_stage), .ftw_stage(ftw_stage), .ptr(ptr));

  word_commit #(.FTW_W(FTW_W), .PH_W(PH_W)) u_commit (
    .clk(clk), .rst(rst), .ld(ld_pulse), .upd(upd_pulse),
    .ph_stage(ph_stage), .ftw_stage(ftw_stage),
    .tune_word(tune_word), .phase_off(phase_off), .ready(ready));
endmodule

// File: rtl/dds_word_loader_chk.sv
module dds_word_loader_chk #(
  parameter int unsigned FTW_W  = 32,
  parameter int unsigned PH_W   = 5,
  parameter int unsigned NBYTES = 5,
  parameter int unsigned PTR_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ld_pulse,
  input logic             upd_pulse,
  input logic [PTR_W-1:0] ptr,
  input logic [FTW_W-1:0] tune_word,
  input logic [PH_W-1:0]  phase_off,
  input logic             ready
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (tune_word == '0 && phase_off == '0 && ready && ptr == '0));

  a_r4_hold_outputs: assert property (@(posedge clk) disable iff (rst)
    !upd_pulse |=> ($stable(tune_word) && $stable(phase_off)));

  a_r8_busy_on_load: assert property (@(posedge clk) disable iff (rst)
    (ld_pulse && !upd_pulse) |=> !ready);

  a_r8_ready_on_commit: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |=> ready);

  a_r7_ptr_cleared: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |=> ptr == '0);

  a_r6_ptr_range: assert property (@(posedge clk) disable iff (rst)
    ptr <= PTR_W'(NBYTES - 1));

  a_r6_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
    (ld_pulse && !upd_pulse && ptr == PTR_W'(NBYTES - 1)) |=> ptr == '0);

  a_r2_idle_ptr: assert property (@(posedge clk) disable iff (rst)
    (!ld_pulse && !upd_pulse) |=> $stable(ptr));
endmodule

bind dds_word_loader dds_word_loader_chk #(
  .FTW_W(FTW_W), .PH_W(PH_W), .NBYTES(NBYTES), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst(rst), .ld_pulse(ld_pulse), .upd_pulse(upd_pulse),
  .ptr(ptr), .tune_word(tune_word), .phase_off(phase_off), .ready(ready));

// File: tb/test_dds_word_loader.sv
module test_dds_word_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_s = 1'b0;
  logic        upd_s = 1'b0;
  logic [7:0]  bus = 8'h00;
  logic [31:0] tune_word;
  logic [4:0]  phase_off;
  logic        ready;
  int          total = 0;
  int          bad = 0;

  dds_word_loader i_dds_word_loader (
    .clk(clk), .rst(rst), .ld_strobe(ld_s), .upd_strobe(upd_s),
    .bus_data(bus), .tune_word(tune_word), .phase_off(phase_off), .ready(ready));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ld(input logic [7:0] b);
    @(negedge clk); bus = b; ld_s = 1'b1;
    repeat (4) @(negedge clk);
    ld_s = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic upd();
    @(negedge clk); upd_s = 1'b1;
    repeat (4) @(negedge clk);
    upd_s = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic put_word(input logic [4:0] ph, input logic [31:0] w);
    ld({ph, 3'b101});
    ld(w[31:24]); ld(w[23:16]); ld(w[15:8]); ld(w[7:0]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset tune", tune_word, 32'h0);
    chk("R1 reset phase", 32'(phase_off), 32'h0);
    chk("R1 reset ready", 32'(ready), 32'h1);

    // R8 / R4: loads do not touch outputs, ready drops
    ld(8'h48);
    chk("R8 ready low after first byte", 32'(ready), 32'h0);
    ld(8'hDE); ld(8'hAD); ld(8'hBE); ld(8'hEF);
    chk("R4 tune unchanged before commit", tune_word, 32'h0);
    chk("R4 phase unchanged before commit", 32'(phase_off), 32'h0);

    // R5: edge-exact commit latency
    @(negedge clk); upd_s = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R5 old tune at second edge", tune_word, 32'h0);
    @(posedge clk); #1;
    chk("R5 new tune at third edge", tune_word, 32'hDEADBEEF);
    chk("R5 new phase at third edge", 32'(phase_off), 32'd9);
    repeat (3) @(negedge clk);
    upd_s = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 ready high after commit", 32'(ready), 32'h1);

    // R3: exhaustive sweep of the first byte
    for (int v = 0; v < 256; v++) begin
      logic [31:0] w;
      w = (32'(v) * 32'h01010101) ^ 32'h5A3C9617;
      ld(8'(v)); ld(w[31:24]); ld(w[23:16]); ld(w[15:8]); ld(w[7:0]);
      upd();
      chk("R3 phase from byte0[7:3]", 32'(phase_off), 32'(v) >> 3);
      chk("R3 tune byte order", tune_word, w);
    end

    // R3: walking one across the tuning word
    for (int b = 0; b < 32; b++) begin
      put_word(5'(b), 32'h1 << b);
      upd();
      chk("R3 walking one tune", tune_word, 32'h1 << b);
    end

    // R6: sixth byte wraps onto position 0
    put_word(5'd2, 32'h01020304);
    ld(8'h38);
    upd();
    chk("R6 wrap phase", 32'(phase_off), 32'd7);
    chk("R6 wrap tune", tune_word, 32'h01020304);

    // R10: partial word keeps older bytes
    ld(8'h50); ld(8'hEE);
    upd();
    chk("R10 partial phase", 32'(phase_off), 32'd10);
    chk("R10 partial tune", tune_word, 32'hEE020304);

    // R2: a long-held strobe stores one byte only
    @(negedge clk); bus = 8'h98; ld_s = 1'b1;
    repeat (20) @(negedge clk);
    ld_s = 1'b0;
    repeat (3) @(negedge clk);
    upd();
    chk("R2 held strobe phase", 32'(phase_off), 32'd19);
    chk("R2 held strobe tune", tune_word, 32'hEE020304);

    // R9 / R7: coinciding strobes
    put_word(5'd3, 32'h11223344);
    upd();
    ld(8'hF8); ld(8'hAB);
    @(negedge clk); bus = 8'hCD; ld_s = 1'b1; upd_s = 1'b1;
    repeat (4) @(negedge clk);
    ld_s = 1'b0; upd_s = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 commit wins phase", 32'(phase_off), 32'd31);
    chk("R9 commit wins tune", tune_word, 32'hAB223344);
    ld(8'h08);
    upd();
    chk("R7 pointer back to byte0", 32'(phase_off), 32'd1);
    chk("R9 concurrent byte discarded", tune_word, 32'hAB223344);

    // R1: mid-run reset clears staging too
    ld(8'hFF); ld(8'h77);
    do_reset();
    chk("R1 mid reset tune", tune_word, 32'h0);
    chk("R1 mid reset ready", 32'(ready), 32'h1);
    upd();
    chk("R1 staging cleared tune", tune_word, 32'h0);
    chk("R1 staging cleared phase", 32'(phase_off), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule